// File: doc/BRIEF.md
# Phase-Two Clock Divider with High-Phase Wait Stretching

This block derives the processor's phase-two clock from a fast oscillator clock. With no slow access pending, phase two toggles on every oscillator edge, giving a symmetric period of two oscillator cycles. Slow peripherals get extra access time by holding phase two in its high phase for one or two additional oscillator cycles. The processor's ready input is never used for this purpose.

Address decoding outside the block raises a slow-access request and chooses how many wait cycles are needed. Both inputs are sampled on the oscillator edge that drives phase two high. A loadable synchronous up-counter receives a preset of the bitwise complement of the wait count on that edge. It counts while phase two stays high, and phase two falls on the edge after the counter reaches all ones. A status flag marks each extra high-phase cycle.

Top module: `phi2_stretcher`

## Requirements
- R1: A synchronous reset drives phi2 low and stretch_active low on the next oscillator edge, even in the middle of a stretch. The first edge after reset is released drives phi2 high.
- R2: When slow_req is low on the edge that raises phi2, phi2 stays high for exactly one oscillator cycle.
- R3: When slow_req is high and wait_sel is 0 on the edge that raises phi2, phi2 stays high for exactly two oscillator cycles, which is one wait state.
- R4: When slow_req is high and wait_sel is 1 on the edge that raises phi2, phi2 stays high for exactly three oscillator cycles, which is two wait states.
- R5: The low phase of phi2 always lasts exactly one oscillator cycle, including after a stretched high phase.
- R6: stretch_active is high in the second and third high-phase cycles, which are the extra cycles, and low in the first high-phase cycle and in every low-phase cycle.
- R7: Changes on slow_req or wait_sel while phi2 is high do not alter the length of the current high phase.
- R8: Slow requests on consecutive phase-two cycles are each stretched by their own wait count, with a single-cycle low phase between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_req | input | 1 | Current access targets a slow device |
| wait_sel | input | SEL_W (1) | Wait count minus one: 0 gives one wait, 1 gives two |
| phi2 | output | 1 | Generated phase-two clock |
| stretch_active | output | 1 | High during each extra high-phase cycle |

## Verification
Two functions can fall in the same oscillator cycle. The first is the end of a stretch, where the counter reaches its terminal value and phi2 falls. The second is a change of the request inputs, which the block must ignore until the next rising edge. The bench drives both inputs to their opposite values in every high-phase cycle, including the final one. It then judges the high-phase length against the value sampled at the rising edge. Reset is also asserted during an extra high cycle. The bench expects phi2 and the flag to be low on the next edge, and a clean restart after that.

// File: rtl/phi2s_pkg.sv
package phi2s_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Number of extra high-phase cycles for a request; clamped to the limit.
    function automatic int unsigned waits_for(input logic slow,
                                              input int unsigned sel,
                                              input int unsigned max_wait);
        if (!slow)
            return 0;
        if (sel + 1 > max_wait)
            return max_wait;
        return sel + 1;
    endfunction

endpackage

// File: rtl/phi2s_preset.sv
module phi2s_preset
    import phi2s_pkg::*;
#(
    parameter int MAX_WAIT = 2,
    parameter int SEL_W    = 1,
    parameter int CNT_W    = 2
) (
    input  logic             slow_req,
    input  logic [SEL_W-1:0] wait_sel,
    output logic [CNT_W-1:0] preset
);
    logic [CNT_W-1:0] waits;

    always_comb begin
        waits  = CNT_W'(waits_for(slow_req, 32'(wait_sel), MAX_WAIT));
        // Complement equals (all ones - waits): that many increments to terminal.
        preset = ~waits;
    end
endmodule

// File: rtl/phi2s_hold_counter.sv
module phi2s_hold_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             inc,
    input  logic [CNT_W-1:0] preset,
    output logic             at_term
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= preset;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign at_term = &cnt;
endmodule

// File: rtl/phi2s_phase_gen.sv
module phi2s_phase_gen
    import phi2s_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic at_term,
    output logic load,
    output logic inc,
    output logic phi2,
    output logic extra
);
    phase_e phase;

    always_comb begin
        load = (phase == PH_LOW);
        inc  = (phase == PH_HIGH) && !at_term;
        phi2 = (phase == PH_HIGH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LOW;
            extra <= 1'b0;
        end else begin
            unique case (phase)
                PH_LOW:  phase <= PH_HIGH;
                PH_HIGH: phase <= at_term ? PH_LOW : PH_HIGH;
                default: phase <= PH_LOW;
            endcase
            extra <= (phase == PH_HIGH) && !at_term;
        end
    end
endmodule

// File: rtl/phi2_stretcher.sv
module phi2_stretcher
    import phi2s_pkg::*;
#(
    parameter int MAX_WAIT = 2,
    localparam int SEL_W   = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1,
    localparam int CNT_W   = $clog2(MAX_WAIT + 1)
) (
    input  logic             clk_osc,
    input  logic             rst,
    input  logic             slow_req,
    input  logic [SEL_W-1:0] wait_sel,
    output logic             phi2,
    output logic             stretch_active
);
    logic [CNT_W-1:0] preset;
    logic             load, inc, at_term;

    phi2s_preset #(.MAX_WAIT(MAX_WAIT), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_preset (
        .slow_req (slow_req),
        .wait_sel (wait_sel),
        .preset   (preset)
    );

    phi2s_hold_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk_osc),
        .rst     (rst),
        .load    (load),
        .inc     (inc),
        .preset  (preset),
        .at_term (at_term)
    );

    phi2s_phase_gen u_phase (
        .clk     (clk_osc),
        .rst     (rst),
        .at_term (at_term),
        .load    (load),
        .inc     (inc),
        .phi2    (phi2),
        .extra   (stretch_active)
    );
endmodule

// File: rtl/phi2s_checker.sv
module phi2s_checker #(
    parameter int SEL_W = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             slow_req,
    input logic [SEL_W-1:0] wait_sel,
    input logic             phi2,
    input logic             stretch_active
);
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (!phi2 && !stretch_active));

    assert_fast_high_R2: assert property (@(posedge clk) disable iff (rst)
        (!phi2 && !slow_req) |=> phi2 ##1 !phi2);

    assert_one_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (!phi2 && slow_req && wait_sel == SEL_W'(0)) |=> phi2 ##1 phi2 ##1 !phi2);

    assert_two_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (!phi2 && slow_req && wait_sel == SEL_W'(1)) |=> phi2 ##1 phi2 ##1 phi2 ##1 !phi2);

    assert_low_single_R5: assert property (@(posedge clk) disable iff (rst)
        !phi2 |=> phi2);

    assert_flag_in_high_R6: assert property (@(posedge clk) disable iff (rst)
        stretch_active |-> phi2);

    assert_flag_pattern_R6: assert property (@(posedge clk) disable iff (rst)
        (!phi2 && slow_req && wait_sel == SEL_W'(1))
            |=> !stretch_active ##1 stretch_active ##1 stretch_active ##1 !stretch_active);
endmodule

bind phi2_stretcher phi2s_checker #(.SEL_W(SEL_W)) u_chk (
    .clk            (clk_osc),
    .rst            (rst),
    .slow_req       (slow_req),
    .wait_sel       (wait_sel),
    .phi2           (phi2),
    .stretch_active (stretch_active)
);

// File: tb/sim_phi2_stretcher.sv
module sim_phi2_stretcher;
    localparam int CLK_P = 10;
    localparam int NVEC  = 12;
    // Fields: [5] slow_req, [4] wait_sel, [3] toggle inputs while high, [2:0] expected high cycles
    localparam logic [5:0] VEC [NVEC] = '{
        6'b0_0_0_001, 6'b1_0_0_010, 6'b1_1_0_011, 6'b0_1_0_001,
        6'b1_1_0_011, 6'b1_1_0_011, 6'b1_0_0_010, 6'b1_1_0_011,
        6'b0_0_1_001, 6'b1_0_1_010, 6'b1_1_1_011, 6'b0_1_1_001
    };

    logic clk_osc = 1'b0;
    logic rst = 1'b1;
    logic slow_req = 1'b0;
    logic [0:0] wait_sel = 1'b0;
    logic phi2, stretch_active;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk_osc = ~clk_osc;

    phi2_stretcher u0 (
        .clk_osc        (clk_osc),
        .rst            (rst),
        .slow_req       (slow_req),
        .wait_sel       (wait_sel),
        .phi2           (phi2),
        .stretch_active (stretch_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Entry: just past a falling clock edge, inside a low phase of phi2.
    task automatic run_cycle(input logic s, input logic w, input logic noise,
                             input int exp_hi, input string req);
        int hi = 0;
        slow_req = s;
        wait_sel = w;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk_osc);
            if (k == 0) chk(phi2 == 1'b1, "R5 low phase length", int'(phi2), 1);
            if (!phi2) break;
            chk(stretch_active == (hi > 0), "R6 stretch flag", int'(stretch_active), int'(hi > 0));
            hi++;
            if (noise) begin
                slow_req = !s;
                wait_sel = !w;
            end
        end
        chk(hi == exp_hi, req, hi, exp_hi);
        chk(stretch_active == 1'b0, "R6 flag in low phase", int'(stretch_active), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk_osc);
        chk(phi2 == 1'b0, "R1 phi2 in reset", int'(phi2), 0);
        chk(stretch_active == 1'b0, "R1 flag in reset", int'(stretch_active), 0);
        rst = 1'b0;
        @(negedge clk_osc);
        chk(phi2 == 1'b1, "R1 first edge raises phi2", int'(phi2), 1);
        @(negedge clk_osc);
        chk(phi2 == 1'b0, "R2 fast high after reset", int'(phi2), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [5:0] v = VEC[i];
            string tag;
            if (v[3])                        tag = "R7 inputs ignored while high";
            else if (i > 0 && v[5] && VEC[i-1][5]) tag = "R8 back-to-back slow";
            else if (v[2:0] == 3'd1)         tag = "R2 fast high length";
            else if (v[2:0] == 3'd2)         tag = "R3 one wait length";
            else                             tag = "R4 two wait length";
            run_cycle(v[5], v[4], v[3], int'(v[2:0]), tag);
        end

        // R1: reset during an extra high cycle of a two-wait stretch
        slow_req = 1'b1;
        wait_sel = 1'b1;
        @(negedge clk_osc);
        chk(phi2 == 1'b1, "R4 stretch started", int'(phi2), 1);
        @(negedge clk_osc);
        chk(stretch_active == 1'b1, "R6 first extra cycle", int'(stretch_active), 1);
        rst = 1'b1;
        @(negedge clk_osc);
        chk(phi2 == 1'b0, "R1 reset mid-stretch phi2", int'(phi2), 0);
        chk(stretch_active == 1'b0, "R1 reset mid-stretch flag", int'(stretch_active), 0);
        rst = 1'b0;
        slow_req = 1'b0;
        @(negedge clk_osc);
        chk(phi2 == 1'b1, "R1 restart after reset", int'(phi2), 1);
        @(negedge clk_osc);
        chk(phi2 == 1'b0, "R2 fast after restart", int'(phi2), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 2000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule